// File: doc/BRIEF.md
# Neural Accelerator Instruction Sequencer

This block is the control unit of a small matrix-inference accelerator. It reads 32-bit instruction words from a 32-entry instruction memory that answers one cycle after a read request, and latches each word. It decodes the 6-bit opcode in the top bits and hands the work to one functional unit at a time. Each unit receives a one-cycle go pulse and answers with a done signal. The sequencer then steps its program counter and fetches the next word. It does this until it meets a halt word.

A host pulses `start` once the program has been loaded. Each instruction then passes through fetch, wait, decode, execute and advance states, and the cost per instruction is five cycles plus the extra cycles the unit needs. The fields of the latched word (buffer select, external address, two tile addresses, shift amount, transpose flag and bias-bypass flag) are driven continuously for the units to use. A swap strobe tells the double-buffered operand stores to exchange halves after an operand load. After a halt word the block stays halted with `npu_done` raised, and only reset takes it out of that state.

Top module: `npu_seq`

## Requirements
- R1: While reset is low and right after it is released, `imem_rd_en`, `unit_go`, `pp_swap` and `npu_done` are all 0, and the first fetch after the next start reads address 0.
- R2: In the idle state the block issues no fetch until `start` is sampled high. The first fetch comes in the cycle after that sample. A `start` pulse while a program is running, or after a halt, has no effect.
- R3: A fetch raises `imem_rd_en` for exactly one cycle with `imem_addr` equal to the program counter. The word on `imem_rdata` one cycle later is latched, and it is decoded in the following cycle. The opcode is bits [31:26].
- R4: A unit opcode produces exactly one single-cycle pulse on `unit_go`, 3 cycles after its fetch cycle. At most one bit of `unit_go` is ever high. The unit index is taken from the opcode: 000000 gives 0, 000001 gives 1, 000010 gives 2, 000011 gives 3, 000100 gives 4, 000101 gives 5, 000110 gives 6, 000111 gives 7, 001001 gives 8 and 010000 gives 9.
- R5: The execute state holds until the `unit_done` bit of the dispatched unit is sampled high. A done seen in the go cycle counts. Done bits of other units are ignored.
- R6: NOP (111110), POOL (001000) and every opcode not listed in R4 or R9 spend exactly one cycle in execute and pulse no unit. The next fetch comes 5 cycles after theirs.
- R7: One cycle after execute ends, the program counter advances by one modulo 32, and the next fetch follows in the cycle after that. A program with no halt continues from address 0 after address 31.
- R8: `pp_swap` is high for one cycle, the cycle before the next fetch, after opcodes 000000, 000001 and 010000 only.
- R9: The halt opcode 111111 raises `npu_done` 3 cycles after its fetch. `npu_done` then stays high with no further fetch or go pulse until reset.
- R10: From decode until the next fetch, the field outputs reflect the latched word: `buf_sel` is [25:22], `ext_addr` is [21:16], `tile_b` is [15:8], `tile_a` is [7:0], `w_transpose` is [6], `shift_amt` is [5:1] and `bias_bypass` is [0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Host pulse that starts execution from the idle state |
| imem_rdata | input | 32 | Instruction word, valid one cycle after a read |
| unit_done | input | 10 | Completion signal of each functional unit |
| imem_rd_en | output | 1 | Instruction memory read request |
| imem_addr | output | 5 | Instruction memory address (program counter) |
| buf_sel | output | 4 | Buffer select field of the latched word |
| ext_addr | output | 6 | External address field |
| tile_a | output | 8 | First tile address field |
| tile_b | output | 8 | Second tile address field |
| shift_amt | output | 5 | Requantization shift field |
| w_transpose | output | 1 | Weight-transpose flag |
| bias_bypass | output | 1 | Bias-bypass flag |
| unit_go | output | 10 | One-cycle go pulse, one bit per unit |
| pp_swap | output | 1 | Double-buffer swap strobe |
| npu_done | output | 1 | Halted indicator, held until reset |

## Verification
The hardest situation to reach from the ports is a unit's done that arrives while a different unit is being waited on. The bench's unit model raises a stray done on a neighbouring unit in the go cycle whenever the real unit's latency is one cycle or more. The timing of the next fetch then shows whether that stray done was ignored. Program-counter wrap needs a halt-free program to run past address 31, so one run fills all 32 words without a halt and follows 40 fetches. Start pulses are also injected in mid-run and after the halt, and the fetch log must show no change from them.

// File: rtl/npu_seq_pkg.sv
package npu_seq_pkg;

  localparam int INSTR_W   = 32;
  localparam int OPC_W     = 6;
  localparam int NUM_UNITS = 10;
  localparam int UNIT_W    = $clog2(NUM_UNITS);

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_FETCH  = 3'd1,
    ST_STALL  = 3'd2,
    ST_DECODE = 3'd3,
    ST_EXEC   = 3'd4,
    ST_NEXT   = 3'd5,
    ST_HALTED = 3'd6
  } seq_state_t;

  localparam logic [OPC_W-1:0] OPC_LD_ACT   = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LD_WGT   = 6'b000001;
  localparam logic [OPC_W-1:0] OPC_LD_BIAS  = 6'b000010;
  localparam logic [OPC_W-1:0] OPC_LD_SCALE = 6'b000011;
  localparam logic [OPC_W-1:0] OPC_MATMUL   = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_BIAS_ADD = 6'b000101;
  localparam logic [OPC_W-1:0] OPC_REQUANT  = 6'b000110;
  localparam logic [OPC_W-1:0] OPC_RECTIFY  = 6'b000111;
  localparam logic [OPC_W-1:0] OPC_POOL     = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_WRITEOUT = 6'b001001;
  localparam logic [OPC_W-1:0] OPC_LD_BOTH  = 6'b010000;
  localparam logic [OPC_W-1:0] OPC_NOP      = 6'b111110;
  localparam logic [OPC_W-1:0] OPC_HALT     = 6'b111111;

  localparam int U_LD_ACT   = 0;
  localparam int U_LD_WGT   = 1;
  localparam int U_LD_BIAS  = 2;
  localparam int U_LD_SCALE = 3;
  localparam int U_MATMUL   = 4;
  localparam int U_BIAS_ADD = 5;
  localparam int U_REQUANT  = 6;
  localparam int U_RECTIFY  = 7;
  localparam int U_WRITEOUT = 8;
  localparam int U_LD_BOTH  = 9;

  typedef struct packed {
    logic [3:0] buf_sel;
    logic [5:0] ext_addr;
    logic [7:0] tile_b;
    logic [7:0] tile_a;
    logic [4:0] shift;
    logic       w_transpose;
    logic       bias_bypass;
  } instr_fields_t;

  typedef struct packed {
    logic              is_halt;
    logic              has_unit;
    logic [UNIT_W-1:0] unit;
    logic              needs_swap;
  } op_class_t;

  function automatic op_class_t unit_op(input int idx, input logic swap);
    op_class_t c;
    c.is_halt    = 1'b0;
    c.has_unit   = 1'b1;
    c.unit       = UNIT_W'(idx);
    c.needs_swap = swap;
    return c;
  endfunction

  function automatic op_class_t classify_op(input logic [OPC_W-1:0] opc);
    op_class_t c;
    c = '0;
    case (opc)
      OPC_LD_ACT:   c = unit_op(U_LD_ACT,   1'b1);
      OPC_LD_WGT:   c = unit_op(U_LD_WGT,   1'b1);
      OPC_LD_BIAS:  c = unit_op(U_LD_BIAS,  1'b0);
      OPC_LD_SCALE: c = unit_op(U_LD_SCALE, 1'b0);
      OPC_MATMUL:   c = unit_op(U_MATMUL,   1'b0);
      OPC_BIAS_ADD: c = unit_op(U_BIAS_ADD, 1'b0);
      OPC_REQUANT:  c = unit_op(U_REQUANT,  1'b0);
      OPC_RECTIFY:  c = unit_op(U_RECTIFY,  1'b0);
      OPC_WRITEOUT: c = unit_op(U_WRITEOUT, 1'b0);
      OPC_LD_BOTH:  c = unit_op(U_LD_BOTH,  1'b1);
      OPC_HALT:     c.is_halt = 1'b1;
      default:      c = '0;
    endcase
    return c;
  endfunction

  function automatic instr_fields_t split_fields(input logic [INSTR_W-1:0] w);
    instr_fields_t f;
    f.buf_sel     = w[25:22];
    f.ext_addr    = w[21:16];
    f.tile_b      = w[15:8];
    f.tile_a      = w[7:0];
    f.shift       = w[5:1];
    f.w_transpose = w[6];
    f.bias_bypass = w[0];
    return f;
  endfunction

endpackage

// File: rtl/seq_fetch.sv
module seq_fetch #(
  parameter int PC_W = 5,
  parameter int W    = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fetch,
  input  logic            latch,
  input  logic            advance,
  input  logic [W-1:0]    rdata,
  output logic [PC_W-1:0] pc,
  output logic [W-1:0]    instr,
  output logic            rd_en,
  output logic [PC_W-1:0] rd_addr
);

  logic [PC_W-1:0] pc_q;
  logic [W-1:0]    instr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= '0;
    end else if (advance) begin
      pc_q <= PC_W'(pc_q + 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_q <= '0;
    end else if (latch) begin
      instr_q <= rdata;
    end
  end

  assign pc      = pc_q;
  assign instr   = instr_q;
  assign rd_en   = fetch;
  assign rd_addr = pc_q;

endmodule

// File: rtl/seq_decode.sv
module seq_decode
  import npu_seq_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output instr_fields_t      fields,
  output op_class_t          op
);

  logic [OPC_W-1:0] opc;

  assign opc    = instr[INSTR_W-1 -: OPC_W];
  assign op     = classify_op(opc);
  assign fields = split_fields(instr);

endmodule

// File: rtl/seq_dispatch.sv
module seq_dispatch #(
  parameter int NUM_UNITS = 10,
  parameter int UNIT_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fire,
  input  logic [UNIT_W-1:0]    unit_sel,
  input  logic [NUM_UNITS-1:0] unit_done,
  output logic [NUM_UNITS-1:0] go,
  output logic                 done_hit
);

  logic [NUM_UNITS-1:0] go_q;
  logic [NUM_UNITS-1:0] own_q;

  for (genvar i = 0; i < NUM_UNITS; i++) begin : g_unit
    logic picked;
    assign picked = (unit_sel == UNIT_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        go_q[i]  <= 1'b0;
        own_q[i] <= 1'b0;
      end else begin
        go_q[i] <= fire && picked;
        if (fire) begin
          own_q[i] <= picked;
        end
      end
    end
  end

  assign go       = go_q;
  assign done_hit = |(unit_done & own_q);

endmodule

// File: rtl/npu_seq.sv
module npu_seq
  import npu_seq_pkg::*;
#(
  parameter int PC_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [31:0]          imem_rdata,
  input  logic [9:0]           unit_done,
  output logic                 imem_rd_en,
  output logic [PC_W-1:0]      imem_addr,
  output logic [3:0]           buf_sel,
  output logic [5:0]           ext_addr,
  output logic [7:0]           tile_a,
  output logic [7:0]           tile_b,
  output logic [4:0]           shift_amt,
  output logic                 w_transpose,
  output logic                 bias_bypass,
  output logic [9:0]           unit_go,
  output logic                 pp_swap,
  output logic                 npu_done
);

  seq_state_t     state_q, state_d;
  logic [PC_W-1:0]    pc_q;
  logic [INSTR_W-1:0] instr_q;
  instr_fields_t  fields;
  op_class_t      op;

  // named internal events
  logic in_fetch, in_stall, in_decode, in_exec, in_next;
  logic exec_fire;
  logic done_hit;
  logic exec_leave;

  assign in_fetch  = (state_q == ST_FETCH);
  assign in_stall  = (state_q == ST_STALL);
  assign in_decode = (state_q == ST_DECODE);
  assign in_exec   = (state_q == ST_EXEC);
  assign in_next   = (state_q == ST_NEXT);

  assign exec_fire  = in_decode && op.has_unit;
  assign exec_leave = in_exec && (!op.has_unit || done_hit);

  seq_fetch #(.PC_W(PC_W), .W(INSTR_W)) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .fetch   (in_fetch),
    .latch   (in_stall),
    .advance (in_next),
    .rdata   (imem_rdata),
    .pc      (pc_q),
    .instr   (instr_q),
    .rd_en   (imem_rd_en),
    .rd_addr (imem_addr)
  );

  seq_decode u_decode (
    .instr  (instr_q),
    .fields (fields),
    .op     (op)
  );

  seq_dispatch #(.NUM_UNITS(NUM_UNITS), .UNIT_W(UNIT_W)) u_dispatch (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (exec_fire),
    .unit_sel  (op.unit),
    .unit_done (unit_done),
    .go        (unit_go),
    .done_hit  (done_hit)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (start) state_d = ST_FETCH;
      ST_FETCH:  state_d = ST_STALL;
      ST_STALL:  state_d = ST_DECODE;
      ST_DECODE: state_d = op.is_halt ? ST_HALTED : ST_EXEC;
      ST_EXEC:   if (exec_leave) state_d = ST_NEXT;
      ST_NEXT:   state_d = ST_FETCH;
      ST_HALTED: state_d = ST_HALTED;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign buf_sel     = fields.buf_sel;
  assign ext_addr    = fields.ext_addr;
  assign tile_a      = fields.tile_a;
  assign tile_b      = fields.tile_b;
  assign shift_amt   = fields.shift;
  assign w_transpose = fields.w_transpose;
  assign bias_bypass = fields.bias_bypass;

  assign pp_swap  = in_next && op.needs_swap;
  assign npu_done = (state_q == ST_HALTED);

endmodule

// File: rtl/npu_seq_checker.sv
module npu_seq_checker
  import npu_seq_pkg::*;
#(
  parameter int PC_W = 5
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input seq_state_t         state_q,
  input logic [PC_W-1:0]    pc,
  input logic [INSTR_W-1:0] instr,
  input logic               has_unit,
  input logic               imem_rd_en,
  input logic [NUM_UNITS-1:0] unit_go,
  input logic               exec_fire,
  input logic               done_hit,
  input logic               pp_swap,
  input logic               npu_done
);

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE && !imem_rd_en));

  assert_fetch_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd_en |=> (!imem_rd_en && state_q == ST_STALL));

  assert_go_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_go));

  assert_go_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (unit_go != '0) |=> (unit_go == '0));

  assert_go_after_decode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_fire |=> ($countones(unit_go) == 1));

  assert_wait_for_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC && has_unit && !done_hit) |=> (state_q == ST_EXEC));

  assert_pc_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_NEXT) |=> (pc == PC_W'($past(pc) + 1'b1) && imem_rd_en));

  assert_swap_then_fetch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    pp_swap |=> imem_rd_en);

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    npu_done |=> (npu_done && !imem_rd_en && unit_go == '0));

  assert_fields_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC) |-> $stable(instr));

endmodule

bind npu_seq npu_seq_checker #(.PC_W(PC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .state_q    (state_q),
  .pc         (pc_q),
  .instr      (instr_q),
  .has_unit   (op.has_unit),
  .imem_rd_en (imem_rd_en),
  .unit_go    (unit_go),
  .exec_fire  (exec_fire),
  .done_hit   (done_hit),
  .pp_swap    (pp_swap),
  .npu_done   (npu_done)
);

// File: tb/npu_seq_test.sv
module npu_seq_test;

  localparam int NU = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [31:0] imem_rdata = '0;
  logic [NU-1:0] unit_done = '0;
  logic imem_rd_en;
  logic [4:0] imem_addr;
  logic [3:0] buf_sel;
  logic [5:0] ext_addr;
  logic [7:0] tile_a, tile_b;
  logic [4:0] shift_amt;
  logic w_transpose, bias_bypass;
  logic [NU-1:0] unit_go;
  logic pp_swap, npu_done;

  always #4 clk = ~clk;

  npu_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .imem_rdata(imem_rdata),
    .unit_done(unit_done), .imem_rd_en(imem_rd_en), .imem_addr(imem_addr),
    .buf_sel(buf_sel), .ext_addr(ext_addr), .tile_a(tile_a), .tile_b(tile_b),
    .shift_amt(shift_amt), .w_transpose(w_transpose), .bias_bypass(bias_bypass),
    .unit_go(unit_go), .pp_swap(pp_swap), .npu_done(npu_done)
  );

  logic [31:0] mem [32];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  int n_fetch = 0, n_go = 0, n_swap = 0, done_first = -1;
  int f_cyc [256];
  int f_addr [256];
  int g_cyc [256];
  int g_idx [256];
  int g_fa [256];
  int g_fc [256];
  int s_cyc [256];
  int lat_seed = 0;
  bit spur_en = 1'b0;
  int pend_cnt = 0;
  int pend_idx = 0;

  task automatic chk(input bit ok, input string tag, input longint got, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, got, exp);
    end
  endtask

  function automatic int lat_of(input int k);
    return (k * 5 + lat_seed) % 4;
  endfunction

  function automatic int exp_unit(input logic [5:0] opc);
    if (opc <= 6'd7) return int'(opc);
    if (opc == 6'd9) return 8;
    if (opc == 6'd16) return 9;
    return -1;
  endfunction

  function automatic bit exp_swap(input logic [5:0] opc);
    return (opc == 6'd0) || (opc == 6'd1) || (opc == 6'd16);
  endfunction

  function automatic logic [31:0] rand_word();
    logic [5:0] pick [16];
    pick = '{6'd0, 6'd1, 6'd2, 6'd3, 6'd4, 6'd5, 6'd6, 6'd7,
             6'd9, 6'd16, 6'd8, 6'd62, 6'd62, 6'd42, 6'd17, 6'd33};
    return {pick[$urandom % 16], 26'($urandom)};
  endfunction

  // instruction memory model: one cycle read latency
  initial forever begin
    @(posedge clk);
    if (imem_rd_en) imem_rdata <= mem[imem_addr];
  end

  // monitor and unit responders
  initial forever begin
    int idx;
    @(negedge clk);
    cyc++;
    if (!rst_n) begin
      pend_cnt = 0;
      unit_done = '0;
    end else begin
      if (imem_rd_en && n_fetch < 256) begin
        f_cyc[n_fetch] = cyc; f_addr[n_fetch] = int'(imem_addr); n_fetch++;
      end
      if (pp_swap && n_swap < 256) begin s_cyc[n_swap] = cyc; n_swap++; end
      if (npu_done && done_first < 0) done_first = cyc;
      unit_done = '0;
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) unit_done[pend_idx] = 1'b1;
      end
      if (unit_go != '0) begin
        idx = 99;
        for (int i = 0; i < NU; i++) if (unit_go[i]) idx = i;
        if ($countones(unit_go) != 1) idx = 99;
        if (n_go < 256) begin
          g_cyc[n_go] = cyc; g_idx[n_go] = idx;
          g_fa[n_go] = int'({buf_sel, ext_addr, tile_b, tile_a});
          g_fc[n_go] = int'({w_transpose, shift_amt, bias_bypass});
        end
        if (idx < NU) begin
          if (lat_of(n_go) == 0) unit_done[idx] = 1'b1;
          else begin
            pend_cnt = lat_of(n_go);
            pend_idx = idx;
            if (spur_en) unit_done[(idx + 1) % NU] = 1'b1;
          end
        end
        n_go++;
      end
    end
  end

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(!imem_rd_en && unit_go == '0 && !pp_swap && !npu_done, "R1 outputs quiet in reset",
        {imem_rd_en, unit_go, pp_swap, npu_done}, 0);
    rst_n = 1'b1;
  endtask

  task automatic model_check(input int c0, input bit halts, input int max_instr);
    int pc, t, gi, si, L, u;
    logic [31:0] w;
    logic [5:0] opc;
    string ftag;
    pc = 0; t = c0 + 1; gi = 0; si = 0;
    ftag = "R2 first fetch after start";
    for (int k = 0; k < max_instr; k++) begin
      w = mem[pc];
      opc = w[31:26];
      chk(k < n_fetch && f_cyc[k] == t, ftag, f_cyc[k], t);
      chk(f_addr[k] == pc, "R7 fetch address", f_addr[k], pc);
      if (opc == 6'b111111) begin
        chk(done_first == t + 3, "R9 done cycle", done_first, t + 3);
        chk(n_fetch == k + 1, "R9 no fetch after halt", n_fetch, k + 1);
        chk(n_go == gi, "R4 go count", n_go, gi);
        chk(n_swap == si, "R8 swap count", n_swap, si);
        return;
      end
      u = exp_unit(opc);
      if (u >= 0) begin
        L = lat_of(gi);
        chk(g_cyc[gi] == t + 3, "R3 decode-to-go cycle", g_cyc[gi], t + 3);
        chk(g_idx[gi] == u, "R4 go unit index", g_idx[gi], u);
        chk(g_fa[gi] == int'(w[25:0]), "R10 load/store fields", g_fa[gi], w[25:0]);
        chk(g_fc[gi] == int'(w[6:0]), "R10 compute fields", g_fc[gi], w[6:0]);
        if (exp_swap(opc)) begin
          chk(si < n_swap && s_cyc[si] == t + 4 + L, "R8 swap cycle", s_cyc[si], t + 4 + L);
          si++;
        end
        gi++;
        t = t + 5 + L;
        ftag = "R5 fetch after own unit done";
      end else begin
        chk(gi >= n_go || g_cyc[gi] != t + 3, "R6 no go for one-cycle op", g_cyc[gi], 0);
        t = t + 5;
        ftag = "R6 fetch after one-cycle op";
      end
      pc = (pc + 1) % 32;
    end
    if (halts) chk(1'b0, "R9 model reached halt", 0, 1);
  endtask

  task automatic run_prog(input bit halts, input int max_instr, input bit stray);
    int c0, waited;
    @(negedge clk); #1;
    n_fetch = 0; n_go = 0; n_swap = 0; done_first = -1;
    c0 = cyc;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    if (stray) begin
      repeat (20) @(negedge clk);
      #1 start = 1'b1;
      @(negedge clk); #1;
      start = 1'b0;
    end
    waited = 0;
    while ((halts ? (done_first < 0) : (n_fetch < max_instr)) && waited < 5000) begin
      @(negedge clk); #1;
      waited++;
    end
    chk(waited < 5000, "R9 run completes", waited, 0);
    model_check(c0, halts, max_instr);
  endtask

  initial begin
    int nf, len;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 32; i++) mem[i] = {6'b111110, 26'd0};

    // reset state and idle behaviour
    repeat (3) @(negedge clk);
    #1;
    chk(!imem_rd_en && unit_go == '0 && !pp_swap && !npu_done, "R1 outputs quiet in reset",
        {imem_rd_en, unit_go, pp_swap, npu_done}, 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    #1;
    chk(n_fetch == 0, "R2 no fetch without start", n_fetch, 0);
    chk(!npu_done, "R1 done low after reset", npu_done, 0);

    // directed program covering every opcode class
    mem[0]  = {6'b000000, 26'h0A5C3E1};
    mem[1]  = {6'b000001, 26'h3FFFFFF};
    mem[2]  = {6'b000100, 26'h000007F};
    mem[3]  = {6'b111110, 26'h1234567};
    mem[4]  = {6'b001000, 26'h0000000};
    mem[5]  = {6'b101010, 26'h2AAAAAA};
    mem[6]  = {6'b000101, 26'h0000041};
    mem[7]  = {6'b000110, 26'h000003E};
    mem[8]  = {6'b000111, 26'h1555555};
    mem[9]  = {6'b001001, 26'h3C0FF00};
    mem[10] = {6'b010000, 26'h0400001};
    mem[11] = {6'b000010, 26'h00000FF};
    mem[12] = {6'b000011, 26'h0010000};
    mem[13] = {6'b111111, 26'h0000000};
    lat_seed = 1; spur_en = 1'b1;
    run_prog(1'b1, 40, 1'b1);

    // start after halt is ignored, only reset clears
    repeat (3) @(negedge clk);
    #1 nf = n_fetch;
    start = 1'b1;
    @(negedge clk); #1;
    start = 1'b0;
    repeat (10) @(negedge clk);
    #1;
    chk(n_fetch == nf, "R2 start ignored while halted", n_fetch, nf);
    chk(npu_done, "R9 done held", npu_done, 1);
    do_reset();
    chk(!npu_done, "R9 reset clears done", npu_done, 0);

    // halt as first word
    mem[0] = {6'b111111, 26'h3FFFFFF};
    run_prog(1'b1, 2, 1'b0);
    do_reset();

    // random programs
    for (int r = 0; r < 8; r++) begin
      len = 2 + int'($urandom % 29);
      for (int i = 0; i < 32; i++) mem[i] = rand_word();
      mem[len] = {6'b111111, 26'($urandom)};
      lat_seed = int'($urandom % 4);
      spur_en = 1'($urandom % 2);
      run_prog(1'b1, 40, 1'($urandom % 2));
      do_reset();
    end

    // halt-free program wraps the counter
    for (int i = 0; i < 32; i++) mem[i] = rand_word();
    lat_seed = 2; spur_en = 1'b1;
    run_prog(1'b0, 40, 1'b0);
    do_reset();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule